// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This block carries out the two halves of an atomic read-modify-write sequence on 32-bit words for a small processor datapath. The datapath gives it a decoded request: the 5-bit operation field, the second source register index, a word address and the store data. A load-reserved request reads the word at the address and returns it as the destination-register value. It also records a reservation on that address. A store-conditional request looks the address up in the reservation table. If a reservation is found, the store goes to memory, 0 is returned, and the reservation is used up. If none is found, memory is left alone and 1 is returned.

The reservation table holds up to four distinct word addresses at the same time. Its entries are kept in age order: the newest entry sits at the front, and a freed slot is closed up by moving the older entries forward. When the table is full, a load-reserved to a new address drops the oldest entry. A request that cannot be decoded, or a load-reserved with a nonzero second register index, gives an illegal-instruction flag and causes no memory traffic. Requests use a start/done handshake, and memory is reached through a single req/ack port.

Top module: `lrsc_unit`

## Requirements
- R1: The operation is chosen by the 5-bit field taken from instruction bits 31:27: 5'b00010 selects load-reserved and 5'b00011 selects store-conditional. A store-conditional is legal whatever its second register index holds.
- R2: A load-reserved with a nonzero second register index completes with `illegal`=1 and `result`=0. It issues no memory request and creates no reservation.
- R3: A legal load-reserved performs one memory read (`mem_we`=0) at the request address, returns the read word on `result`, and reserves that address.
- R4: A store-conditional to a reserved address performs one memory write of the store data at that address and returns 0.
- R5: A store-conditional to an address that is not reserved performs no memory request and returns 1.
- R6: A successful store-conditional removes its reservation, so a second store-conditional to the same address fails until a new load-reserved is done.
- R7: Reservations on several distinct addresses are held together, and each one is consumed independently.
- R8: Any operation field other than the two in R1 completes with `illegal`=1 and `result`=0, and issues no memory request.
- R9: The table holds 4 entries. A load-reserved to an address already held adds no duplicate and leaves the age order unchanged. A load-reserved to a new address while the table is full evicts the oldest entry.
- R10: Reset clears every reservation and leaves `done` and `mem_req` low.
- R11: `start` is taken while idle. `mem_req` stays high with a stable address until `mem_ack`. `done` is a single-cycle pulse in the cycle after the final `mem_ack`, and `result` and `illegal` are valid while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken while idle |
| op_field | input | 5 | Operation field (instruction bits 31:27) |
| rs2_idx | input | 5 | Second source register index |
| req_addr | input | 32 | Word address |
| req_wdata | input | 32 | Store data for store-conditional |
| done | output | 1 | Completion pulse |
| result | output | 32 | Destination-register value |
| illegal | output | 1 | Illegal-instruction exception |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data |

## Verification
Paired load-reserved / store-conditional sequences show the difference between a hit, which writes and returns 0, and a miss, which returns 1 and issues no write. A repeated store-conditional shows that a reservation is consumed, and interleaved reservations on two addresses show that entries are independent. A fill of four addresses, followed by a repeated load to the oldest one and then a fifth address, shows whether duplicates are suppressed and whether the oldest entry is the one evicted. Illegal encodings, a reservation taken before reset, and a count of memory reads and writes seen at the port show which requests reach memory at all.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

    localparam logic [4:0] FN_LOAD_RSV  = 5'b00010;
    localparam logic [4:0] FN_STORE_CND = 5'b00011;

    typedef enum logic [1:0] {
        K_BAD   = 2'd0,
        K_LOAD  = 2'd1,
        K_STORE = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EVAL = 2'd1,
        S_MEM  = 2'd2,
        S_FIN  = 2'd3
    } state_e;

    function automatic req_kind_e classify(input logic [4:0] fn, input logic [4:0] rs2);
        if (fn == FN_LOAD_RSV)
            return (rs2 == 5'd0) ? K_LOAD : K_BAD;
        else if (fn == FN_STORE_CND)
            return K_STORE;
        else
            return K_BAD;
    endfunction

endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
    import lrsc_pkg::*;
(
    input  logic [4:0] fn,
    input  logic [4:0] rs2,
    output req_kind_e  kind
);
    always_comb kind = classify(fn, rs2);
endmodule

// File: rtl/lrsc_resv_table.sv
module lrsc_resv_table #(
    parameter int ENTRIES = 4,
    parameter int AW      = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          insert,
    input  logic          consume,
    output logic          hit
);
    logic [ENTRIES-1:0] vld;
    logic [AW-1:0]      tag [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] covered;

    assign hit = |match;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        assign match[i] = vld[i] && (tag[i] == addr);
        if (i == 0) begin : g_c0
            assign covered[i] = match[i];
        end else begin : g_cn
            assign covered[i] = covered[i-1] | match[i];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                vld[i] <= 1'b0;
                tag[i] <= '0;
            end else if (insert && !hit) begin
                if (i == 0) begin
                    vld[i] <= 1'b1;
                    tag[i] <= addr;
                end else begin
                    vld[i] <= vld[(i == 0) ? 0 : i-1];
                    tag[i] <= tag[(i == 0) ? 0 : i-1];
                end
            end else if (consume && covered[i]) begin
                if (i == ENTRIES-1) begin
                    vld[i] <= 1'b0;
                end else begin
                    vld[i] <= vld[(i == ENTRIES-1) ? i : i+1];
                    tag[i] <= tag[(i == ENTRIES-1) ? i : i+1];
                end
            end
        end
    end
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
    import lrsc_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int ENTRIES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [4:0]    op_field,
    input  logic [4:0]    rs2_idx,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          done,
    output logic [DW-1:0] result,
    output logic          illegal,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    localparam logic [DW-1:0] SC_FAIL_CODE = DW'(1);

    state_e        state;
    req_kind_e     kind_in, kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] result_q;
    logic          illegal_q;
    logic          tbl_hit, tbl_insert, tbl_consume;

    lrsc_decode u_dec (
        .fn  (op_field),
        .rs2 (rs2_idx),
        .kind(kind_in)
    );

    assign tbl_consume = (state == S_EVAL) && (kind_q == K_STORE);
    assign tbl_insert  = (state == S_MEM) && mem_ack && (kind_q == K_LOAD);

    lrsc_resv_table #(.ENTRIES(ENTRIES), .AW(AW)) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .addr   (addr_q),
        .insert (tbl_insert),
        .consume(tbl_consume),
        .hit    (tbl_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            kind_q    <= K_BAD;
            addr_q    <= '0;
            wdata_q   <= '0;
            result_q  <= '0;
            illegal_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    kind_q    <= kind_in;
                    addr_q    <= req_addr;
                    wdata_q   <= req_wdata;
                    result_q  <= '0;
                    illegal_q <= 1'b0;
                    state     <= S_EVAL;
                end
                S_EVAL: begin
                    unique case (kind_q)
                        K_LOAD:  state <= S_MEM;
                        K_STORE: begin
                            if (tbl_hit) begin
                                state <= S_MEM;
                            end else begin
                                result_q <= SC_FAIL_CODE;
                                state    <= S_FIN;
                            end
                        end
                        default: begin
                            illegal_q <= 1'b1;
                            state     <= S_FIN;
                        end
                    endcase
                end
                S_MEM: if (mem_ack) begin
                    result_q <= (kind_q == K_LOAD) ? mem_rdata : '0;
                    state    <= S_FIN;
                end
                S_FIN: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign done      = (state == S_FIN);
    assign result    = result_q;
    assign illegal   = illegal_q;
    assign mem_req   = (state == S_MEM);
    assign mem_we    = mem_req && (kind_q == K_STORE);
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
endmodule

// File: rtl/lrsc_unit_chk.sv
module lrsc_unit_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          done,
    input logic          illegal,
    input logic [DW-1:0] result,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack
);
    // R11: request held with a stable address until acknowledged
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R11: completion follows the final acknowledge by one cycle
    p_done_after_ack_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> done && !mem_req);

    // R11: completion is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2 / R8: an illegal request never reached memory
    p_illegal_nomem_r2: assert property (@(posedge clk) disable iff (rst)
        done && illegal |-> !$past(mem_req));

    // R5: a legal request that skipped memory is a failed store-conditional
    p_sc_fail_code_r5: assert property (@(posedge clk) disable iff (rst)
        done && !illegal && !$past(mem_req) |-> result == DW'(1));

    // R4: writes only occur inside a memory request
    p_we_in_req_r4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    // R10: reset leaves the handshake outputs low
    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> !done && !mem_req);
endmodule

bind lrsc_unit lrsc_unit_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .done    (done),
    .illegal (illegal),
    .result  (result),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .mem_ack (mem_ack)
);

// File: tb/lrsc_unit_test.sv
module lrsc_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] LR = 5'b00010;
    localparam logic [4:0] SC = 5'b00011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  op_field = '0;
    logic [4:0]  rs2_idx = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        done, illegal, mem_req, mem_we;
    logic [31:0] result, mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [16];
    int rd_cnt = 0;
    int wr_cnt = 0;
    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lrsc_unit uut (
        .clk(clk), .rst(rst), .start(start), .op_field(op_field),
        .rs2_idx(rs2_idx), .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .result(result), .illegal(illegal),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory model: one-cycle latency, one access per request
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[5:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[5:2]];
                rd_cnt <= rd_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    typedef struct packed {
        logic [4:0]  fn;
        logic [4:0]  rs2;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_res;
        logic        exp_ill;
        logic [1:0]  exp_rd;
        logic [1:0]  exp_wr;
        logic [3:0]  rid;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{SC, 5'd0, 32'h10, 32'h1111, 32'd1,          1'b0, 2'd0, 2'd0, 4'd5},  // R5 miss
        '{LR, 5'd0, 32'h10, 32'h0,    32'hA000_0004, 1'b0, 2'd1, 2'd0, 4'd3},  // R3 load
        '{SC, 5'd0, 32'h10, 32'h55,   32'd0,          1'b0, 2'd0, 2'd1, 4'd4},  // R4 hit
        '{SC, 5'd0, 32'h10, 32'h66,   32'd1,          1'b0, 2'd0, 2'd0, 4'd6},  // R6 consumed
        '{LR, 5'd0, 32'h10, 32'h0,    32'h55,         1'b0, 2'd1, 2'd0, 4'd4},  // R4 data landed
        '{LR, 5'd3, 32'h14, 32'h0,    32'd0,          1'b1, 2'd0, 2'd0, 4'd2},  // R2 illegal
        '{SC, 5'd0, 32'h14, 32'h77,   32'd1,          1'b0, 2'd0, 2'd0, 4'd2},  // R2 no reservation
        '{LR, 5'd0, 32'h18, 32'h0,    32'hA000_0006, 1'b0, 2'd1, 2'd0, 4'd7},  // R7 second address
        '{SC, 5'd0, 32'h18, 32'h7,    32'd0,          1'b0, 2'd0, 2'd1, 4'd7},  // R7
        '{SC, 5'd0, 32'h10, 32'h8,    32'd0,          1'b0, 2'd0, 2'd1, 4'd7},  // R7 first still held
        '{5'b00001, 5'd0, 32'h10, 32'h9, 32'd0,       1'b1, 2'd0, 2'd0, 4'd8},  // R8 bad field
        '{SC, 5'd9, 32'h10, 32'h9,    32'd1,          1'b0, 2'd0, 2'd0, 4'd1}   // R1 SC with rs2
    };

    logic [31:0] o_res;
    logic        o_ill;
    logic        o_ack_prev;

    task automatic run_op(input logic [4:0] fn, input logic [4:0] rs2,
                          input logic [31:0] a, input logic [31:0] wd);
        logic seen;
        seen = 1'b0;
        o_ack_prev = 1'b0;
        @(negedge clk);
        start = 1'b1; op_field = fn; rs2_idx = rs2; req_addr = a; req_wdata = wd;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 40; n++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            o_ack_prev = mem_ack;
            @(negedge clk);
        end
        o_res = result;
        o_ill = illegal;
        if (!seen) begin
            checks++; failures++;
            $display("FAIL R11 request timed out: done=0 expected=1");
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired: finished=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int r0, w0;
        for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + i;
        do_reset();
        // R10: reset state at the ports
        chk("R10 done after reset", {31'd0, done}, 32'd0);
        chk("R10 mem_req after reset", {31'd0, mem_req}, 32'd0);

        for (int v = 0; v < NVEC; v++) begin
            r0 = rd_cnt; w0 = wr_cnt;
            run_op(VECS[v].fn, VECS[v].rs2, VECS[v].addr, VECS[v].wdata);
            checks++;
            if (o_res !== VECS[v].exp_res || o_ill !== VECS[v].exp_ill ||
                (rd_cnt - r0) != int'(VECS[v].exp_rd) || (wr_cnt - w0) != int'(VECS[v].exp_wr)) begin
                failures++;
                $display("FAIL R%0d vec %0d actual res=%h ill=%b rd=%0d wr=%0d expected res=%h ill=%b rd=%0d wr=%0d",
                         VECS[v].rid, v, o_res, o_ill, rd_cnt - r0, wr_cnt - w0,
                         VECS[v].exp_res, VECS[v].exp_ill, VECS[v].exp_rd, VECS[v].exp_wr);
            end
        end

        // R11: done follows the acknowledge by one cycle
        run_op(LR, 5'd0, 32'h3C, 32'h0);
        chk("R11 ack in cycle before done", {31'd0, o_ack_prev}, 32'd1);
        chk("R11 result valid with done", o_res, 32'hA000_000F);

        // R9: fill, repeat oldest, add fifth
        run_op(SC, 5'd0, 32'h3C, 32'h0); // drop 0x3C so the table is empty
        run_op(LR, 5'd0, 32'h20, 32'h0);
        run_op(LR, 5'd0, 32'h24, 32'h0);
        run_op(LR, 5'd0, 32'h28, 32'h0);
        run_op(LR, 5'd0, 32'h2C, 32'h0);
        run_op(LR, 5'd0, 32'h20, 32'h0);
        run_op(LR, 5'd0, 32'h30, 32'h0);
        run_op(SC, 5'd0, 32'h20, 32'h1);
        chk("R9 oldest evicted", o_res, 32'd1);
        run_op(SC, 5'd0, 32'h24, 32'h2);
        chk("R9 no duplicate, 0x24 kept", o_res, 32'd0);
        run_op(SC, 5'd0, 32'h28, 32'h3);
        chk("R9 0x28 kept", o_res, 32'd0);
        run_op(SC, 5'd0, 32'h2C, 32'h4);
        chk("R9 0x2C kept", o_res, 32'd0);
        run_op(SC, 5'd0, 32'h30, 32'h5);
        chk("R9 newest kept", o_res, 32'd0);

        // R10: reservation dropped by reset
        run_op(LR, 5'd0, 32'h34, 32'h0);
        do_reset();
        w0 = wr_cnt;
        run_op(SC, 5'd0, 32'h34, 32'hDEAD);
        chk("R10 reservation cleared", o_res, 32'd1);
        chk("R10 no write after reset", wr_cnt - w0, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule